// File: doc/BRIEF.md
# Vertical Line Decimate/Replicate Scaler

This block scales a bilevel page along the sub-scan direction. It never changes the contents of a line. For each line it only decides how many copies of that line go out: none, one, or several. An upstream stage raises a "line available" request. The block accepts the line, emits one strobe per copy on consecutive cycles, and then pulses an acknowledge. The data mover uses that acknowledge to release the line buffer. The block can sit behind any coding, decoding, code conversion or plain transfer path, because it touches only the line cadence.

Two modes exist, and the mode is chosen per line. In fractional mode an unsigned fixed-point factor with 16 fraction bits is added to a phase residue for every line. The carry into the integer part gives the copy count, and the fraction is kept for the next line. This gives factors up to 2.0 in steps of 1/65536. In integer mode every line is repeated exactly N times, where N is a 16-bit count. The residue can be cleared at the start of a page or by an explicit clear.

Top module: `vscale_line_rep`

## Requirements
- R1: While reset is applied and in the first cycle after it, `line_ready` is 1, `emit` is 0 and `line_done` is 0. The phase residue is zero after reset.
- R2: In fractional mode (`mode_int` = 0), an accepted line with residue r and factor f emits floor((r+f)/65536) copies. The new residue is (r+f) mod 65536.
- R3: A fractional factor above 131072 (2.0) is treated as exactly 131072. Such a line emits 2 copies and leaves the residue unchanged.
- R4: In integer mode (`mode_int` = 1), an accepted line emits exactly `rep_count` copies for counts 2 to 65535. The phase residue is not altered by integer-mode lines.
- R5: In integer mode, a `rep_count` of 0 or 1 emits exactly one copy.
- R6: Copies appear as `emit` high on consecutive cycles, starting the cycle after acceptance. `line_done` is high for one cycle, right after the last copy. For a zero-copy line it is high in the cycle after acceptance. `emit` and `line_done` are never high together.
- R7: A line is accepted on a clock edge where `line_valid` and `line_ready` are both 1. `line_ready` stays 0 from the next cycle through the `line_done` cycle, and it is 1 again in the cycle after `line_done`. `line_valid` has no effect while `line_ready` is 0.
- R8: `page_start` or `acc_clear` forces the residue to zero. When either is high in the same cycle as a fractional acceptance, that line is computed from residue zero.
- R9: The mode, factor and count are sampled only at acceptance. Later changes do not alter the copies of the line in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Start of page, clears phase residue |
| acc_clear | input | 1 | Explicit residue clear |
| mode_int | input | 1 | 1 selects integer replication, 0 fractional |
| frac_factor | input | 18 | Fractional factor, 16 fraction bits |
| rep_count | input | 16 | Integer-mode repeat count |
| line_valid | input | 1 | A new input line is available |
| line_ready | output | 1 | Block can accept a line this cycle |
| emit | output | 1 | One output copy of the current line |
| line_done | output | 1 | All copies of the current line issued |

## Verification
The hardest condition to reach from the ports is a residue that is not zero combined with a clear arriving on the exact edge of an acceptance. Other hard cases are a residue that must survive an integer-mode line, and a factor above 2.0 arriving while a residue is pending. The stimulus first loads the residue to one half with a 0.5-factor line. It then issues the clear together with the next acceptance, inserts integer lines, and reads the effect through the copy count of the following fractional line. A behavioural model running alongside compares the ready, emit and done pins every cycle. This includes a pass where `line_valid` is held high through a whole line, and a 65535-fold replication.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_EMIT = 2'd1,
      VS_DONE = 2'd2
   } vs_state_e;

endpackage

// File: rtl/vscale_phase_acc.sv
module vscale_phase_acc #(
   parameter int FRAC_W = 16,
   parameter int FACT_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [FACT_W-1:0] factor,
   output logic [1:0]        copies,
   output logic [FRAC_W-1:0] residue
);
   localparam int SUM_W = FRAC_W + 2;

   logic [SUM_W-1:0]  fac_eff;
   logic [SUM_W-1:0]  sum;
   logic [FRAC_W-1:0] base;
   logic [FRAC_W-1:0] residue_q;

   if (FRAC_W < 2) begin : g_bad_frac
      $error("vscale_phase_acc: FRAC_W must be at least 2");
   end

   // factor wider than 2.0 needs a clamp; narrower ones cannot exceed it
   if (FACT_W > FRAC_W + 1) begin : g_clamp
      localparam logic [FACT_W-1:0] LIM_F = FACT_W'(1) << (FRAC_W + 1);
      always_comb begin
         if (factor > LIM_F) fac_eff = SUM_W'(LIM_F);
         else                fac_eff = factor[SUM_W-1:0];
      end
   end else begin : g_noclamp
      assign fac_eff = SUM_W'(factor);
   end

   assign base    = clr ? '0 : residue_q;
   assign sum     = {2'b00, base} + fac_eff;
   assign copies  = sum[SUM_W-1:FRAC_W];
   assign residue = residue_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    residue_q <= '0;
      else if (step) residue_q <= sum[FRAC_W-1:0];
      else if (clr)  residue_q <= '0;
   end

   p_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !step) |=> (residue_q == '0));

endmodule

// File: rtl/vscale_copy_ctr.sv
module vscale_copy_ctr
   import vscale_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   output logic             ready,
   output logic             emit,
   output logic             done
);
   vs_state_e        state_q;
   logic [CNT_W-1:0] rem_q;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("vscale_copy_ctr: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VS_IDLE;
         rem_q   <= '0;
      end else begin
         unique case (state_q)
            VS_IDLE: if (load) begin
               rem_q   <= load_cnt;
               state_q <= (load_cnt == '0) ? VS_DONE : VS_EMIT;
            end
            VS_EMIT: begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == CNT_W'(1)) state_q <= VS_DONE;
            end
            VS_DONE: state_q <= VS_IDLE;
            default: state_q <= VS_IDLE;
         endcase
      end
   end

   assign ready = (state_q == VS_IDLE);
   assign emit  = (state_q == VS_EMIT);
   assign done  = (state_q == VS_DONE);

   p_last_copy_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (emit && rem_q == CNT_W'(1)) |=> (done && !emit));
   p_emit_done_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(emit && done));

endmodule

// File: rtl/vscale_line_rep.sv
module vscale_line_rep #(
   parameter int FRAC_W = 16,
   parameter int FACT_W = FRAC_W + 2,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic              acc_clear,
   input  logic              mode_int,
   input  logic [FACT_W-1:0] frac_factor,
   input  logic [CNT_W-1:0]  rep_count,
   input  logic              line_valid,
   output logic              line_ready,
   output logic              emit,
   output logic              line_done
);
   localparam logic [FACT_W-1:0] TWO_F = FACT_W'(1) << (FRAC_W + 1);

   logic             take;
   logic             clr_any;
   logic [1:0]       frac_copies;
   logic [FRAC_W-1:0] residue;
   logic [CNT_W-1:0] cnt_sel;

   assign take    = line_valid && line_ready;
   assign clr_any = page_start || acc_clear;

   vscale_phase_acc #(.FRAC_W(FRAC_W), .FACT_W(FACT_W)) acc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_any),
      .step    (take && !mode_int),
      .factor  (frac_factor),
      .copies  (frac_copies),
      .residue (residue)
   );

   always_comb begin
      if (mode_int) cnt_sel = (rep_count == '0) ? CNT_W'(1) : rep_count;
      else          cnt_sel = {{(CNT_W-2){1'b0}}, frac_copies};
   end

   vscale_copy_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_cnt (cnt_sel),
      .ready    (line_ready),
      .emit     (emit),
      .done     (line_done)
   );

   p_busy_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !line_ready);
   p_ready_after_done_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> line_ready);
   p_int_keeps_residue_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode_int && !clr_any) |=> $stable(residue));
   p_clamp_two_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !mode_int && frac_factor > TWO_F) |-> (frac_copies == 2'd2));

endmodule

// File: tb/vscale_line_rep_tb.sv
module vscale_line_rep_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_start = 1'b0;
   logic        acc_clear = 1'b0;
   logic        mode_int = 1'b0;
   logic [17:0] frac_factor = '0;
   logic [15:0] rep_count = '0;
   logic        line_valid = 1'b0;
   logic        line_ready, emit, line_done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vscale_line_rep dut_i (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .acc_clear(acc_clear),
      .mode_int(mode_int), .frac_factor(frac_factor), .rep_count(rep_count),
      .line_valid(line_valid), .line_ready(line_ready), .emit(emit),
      .line_done(line_done)
   );

   // behavioural reference: 0 idle, 1 emitting, 2 done
   int m_st = 0, m_rem = 0, m_res = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_res = 0;
      end else begin
         case (m_st)
            0: begin
               if (line_valid) begin
                  int base, f, s, n;
                  base = (page_start || acc_clear) ? 0 : m_res;
                  if (mode_int) begin
                     n = (rep_count == 0) ? 1 : int'(rep_count);
                     if (page_start || acc_clear) m_res = 0;
                  end else begin
                     f = (frac_factor > 131072) ? 131072 : int'(frac_factor);
                     s = base + f;
                     n = s / 65536;
                     m_res = s % 65536;
                  end
                  m_rem = n;
                  m_st = (n == 0) ? 2 : 1;
               end else if (page_start || acc_clear) m_res = 0;
            end
            1: begin
               m_rem = m_rem - 1;
               if (m_rem == 0) m_st = 2;
            end
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(line_ready == (m_st == 0), "R7 line_ready vs model", line_ready, m_st == 0);
         chk(emit == (m_st == 1), "R6 emit vs model", emit, m_st == 1);
         chk(line_done == (m_st == 2), "R6 line_done vs model", line_done, m_st == 2);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic send(input bit mi, input int fac, input int rep, input bit clr,
                       input bit hold, input int exp, input string tag);
      int n, cycles;
      @(negedge clk);
      while (!line_ready) @(negedge clk);
      mode_int = mi; frac_factor = 18'(fac); rep_count = 16'(rep);
      page_start = clr; line_valid = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
      if (!hold) line_valid = 1'b0;
      // R9: scramble the sampled inputs while the line is in flight
      mode_int = ~mi; frac_factor = 18'h3FFFF; rep_count = 16'd7;
      n = 0; cycles = 1;
      forever begin
         if (emit) n++;
         chk(!line_ready, "R7 busy until done", line_ready, 0);
         if (line_done) break;
         @(negedge clk);
         cycles++;
      end
      chk(n == exp, tag, n, exp);
      chk(cycles == exp + 1, "R6 done cycle after last copy", cycles, exp + 1);
      line_valid = 1'b0;
      @(negedge clk);
      chk(line_ready, "R7 ready after done", line_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(line_ready && !emit && !line_done, "R1 reset outputs", {line_ready, emit, line_done}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_ready && !emit && !line_done, "R1 after reset", {line_ready, emit, line_done}, 3'b100);
      // R1: residue zero after reset -> 0.5 gives zero copies
      send(0, 32'h8000, 0, 0, 0, 0, "R1 residue zero at start");
      // R2 factor 0.5
      send(0, 32'h8000, 0, 1, 0, 0, "R2 half first");
      send(0, 32'h8000, 0, 0, 0, 1, "R2 half second");
      send(0, 32'h8000, 0, 0, 0, 0, "R2 half third");
      send(0, 32'h8000, 0, 0, 0, 1, "R2 half fourth");
      send(0, 32'h10000, 0, 0, 0, 1, "R2 unity");
      // R2 factor 1.5
      send(0, 32'h18000, 0, 1, 0, 1, "R2 one-and-half a");
      send(0, 32'h18000, 0, 0, 0, 2, "R2 one-and-half b");
      send(0, 32'h18000, 0, 0, 0, 1, "R2 one-and-half c");
      // R3 clamp with residue 0x8000 pending
      send(0, 32'h3FFFF, 0, 0, 0, 2, "R3 clamp a");
      send(0, 32'h3FFFF, 0, 0, 0, 2, "R3 clamp b");
      // R8 explicit clear while idle
      @(negedge clk); acc_clear = 1'b1;
      @(negedge clk); acc_clear = 1'b0;
      send(0, 32'h8000, 0, 0, 0, 0, "R8 after acc_clear");
      send(0, 32'h8000, 0, 1, 0, 0, "R8 clear same cycle as accept");
      // R4/R5 integer mode, residue 0x8000 pending
      send(1, 0, 3, 0, 0, 3, "R4 repeat three");
      send(1, 0, 2, 0, 0, 2, "R4 repeat two");
      send(1, 0, 0, 0, 0, 1, "R5 count zero");
      send(1, 0, 1, 0, 0, 1, "R5 count one");
      send(0, 32'h8000, 0, 0, 0, 1, "R4 residue kept over integer lines");
      // R6 zero-copy line
      send(0, 1, 0, 1, 0, 0, "R6 zero copies");
      // R7 valid held high during a line
      send(1, 0, 4, 0, 1, 4, "R7 valid held while busy");
      send(0, 32'h10000, 0, 1, 1, 1, "R7 held valid single copy");
      // R4 full-range count
      send(1, 0, 65535, 0, 0, 65535, "R4 repeat 65535");
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule